// File: doc/BRIEF.md
# SPI Master with Programmable Chip-Select Delays

This block is a single-channel serial peripheral interface master. It runs on the system clock and derives the serial clock by dividing that clock by a count set from an 8-bit prescale field. It always uses the shifted-phase timing. The first data bit is already on the data-out line when chip select falls. Every following bit is launched on the edge that returns the serial clock to its idle level. Incoming data is captured on the edge that leaves the idle level.

Two delays are set in system-clock cycles, and both are added to the serial-clock timing. The first runs from the fall of chip select to the first serial-clock edge. The second runs from the last serial-clock edge to the rise of chip select. A hold option makes the leading delay one cycle longer. The host sets a format word and a delay word, places a transmit word, and pulses `start`. It then waits for the one-cycle `done` pulse and reads the received word.

Top module: `spi_dly_master`

## Requirements
- R1: The serial-clock period is PS+1 system-clock cycles for a prescale PS (format bits [15:8]) from 1 to 255, and 2 cycles for PS=0. Each period has floor(period/2) cycles at the idle level and the remaining cycles at the active level.
- R2: The polarity bit (format bit 17) sets the idle level of the serial clock. Between transfers the serial clock follows that bit. With polarity 0 the active edge is rising; with polarity 1 it is falling.
- R3: When `start` is accepted, `csN` falls on the next clock edge. The first serial-clock edge comes floor(period/2) + D1 + 2 cycles later when the hold bit (format bit 16) is 0, and one cycle later than that when it is 1. D1 is delay-word bits [15:8].
- R4: `csN` rises D2+1 cycles after the last serial-clock edge. D2 is delay-word bits [7:0].
- R5: The character length is format bits [7:0], counted in bits. Values below 2 are treated as 2, and values above 16 as 16. The low bits of `txWord` are sent most significant bit first. The first bit is valid when `csN` falls, and each later bit changes only on a return-to-idle edge. A transfer has exactly twice the character length in serial-clock edges.
- R6: `miso` is sampled on each active edge. `rxWord` holds the sampled bits right-justified, with zeros above the character length.
- R7: `done` is high for exactly one cycle. That cycle is the first one with `csN` high again, and `busy` is low in it. `busy` is high exactly while `csN` is low, and `rxWord` changes only in a `done` cycle.
- R8: A `start` pulse while `busy` is high is ignored. The running transfer goes on unchanged and no second transfer follows it.
- R9: The format and delay words and `txWord` are captured when `start` is accepted. Changing them during a transfer does not alter its timing or data.
- R10: During reset `csN` is 1, `sclk` is 0, `busy` and `done` are 0, and `rxWord` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| fmtWord | input | 18 | Format: [7:0] length, [15:8] prescale, [16] hold, [17] polarity |
| dlyWord | input | 16 | Delays: [15:8] lead count, [7:0] trail count |
| start | input | 1 | Request a transfer when idle |
| txWord | input | 16 | Word to send, right-justified |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle end-of-transfer pulse |
| rxWord | output | 16 | Last received word, right-justified |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| csN | output | 1 | Chip select, active low |

## Verification
The assertions check on every cycle that `busy` and chip select agree and that `done` is a single pulse in the first cycle after release. They also check that an accepted start pulls chip select low, and that the received word changes only at `done`. Edge spacing, the lead and trail counts, the bit order on both data lines and length clamping depend on the programmed fields, so only the bench scenarios can show them. The same holds for a start pulse that is ignored, and for configuration changes made in the middle of a transfer.

// File: rtl/spi_dly_pkg.sv
package spi_dly_pkg;
  localparam int LENF_W       = 8;
  localparam int PS_W         = 8;
  localparam int DLY_W        = 8;
  localparam int FMT_LEN_LSB  = 0;
  localparam int FMT_PS_LSB   = 8;
  localparam int FMT_HOLD_BIT = 16;
  localparam int FMT_POL_BIT  = 17;
  localparam int FMT_W        = 18;
  localparam int DLY_TRL_LSB  = 0;
  localparam int DLY_LED_LSB  = 8;
  localparam int DLYW_W       = 2 * DLY_W;

  typedef struct packed {
    logic load;
    logic sample;
    logic shiftOut;
    logic finish;
  } dpStrobe_t;
endpackage

// File: rtl/spi_dly_ctrl.sv
module spi_dly_ctrl
  import spi_dly_pkg::*;
#(
  parameter int DATA_W = 16,
  localparam int BL_W  = $clog2(DATA_W) + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [LENF_W-1:0] lenIn,
  input  logic [PS_W-1:0]   psIn,
  input  logic              holdIn,
  input  logic              polIn,
  input  logic [DLY_W-1:0]  leadIn,
  input  logic [DLY_W-1:0]  trailIn,
  output logic [BL_W-1:0]   loadLen,
  output dpStrobe_t         stb,
  output logic              sclk,
  output logic              csN,
  output logic              busy,
  output logic              done
);
  localparam int PER_W = PS_W + 1;
  localparam int CNT_W = $clog2((2 ** (PS_W - 1)) + (2 ** DLY_W) + 4);

  typedef enum logic [2:0] {ST_IDLE, ST_LEAD, ST_ACT, ST_INACT, ST_TRAIL} state_t;

  state_t            state;
  logic [CNT_W-1:0]  cnt;
  logic [BL_W-1:0]   bitsLeft;
  logic [PS_W-1:0]   psReg;
  logic              polReg;
  logic [DLY_W-1:0]  trailReg;
  logic [PER_W-1:0]  perReg, perIn, idleHalf, actHalf;
  logic [CNT_W-1:0]  leadLen;
  logic              cntZero;

  function automatic logic [PER_W-1:0] periodOf(input logic [PS_W-1:0] ps);
    return (ps == '0) ? PER_W'(2) : (PER_W'(ps) + PER_W'(1));
  endfunction

  always_comb begin
    perReg   = periodOf(psReg);
    idleHalf = perReg >> 1;
    actHalf  = perReg - idleHalf;
    perIn    = periodOf(psIn);
    leadLen  = CNT_W'(perIn >> 1) + CNT_W'(leadIn) + CNT_W'(2) + CNT_W'(holdIn);
    if (lenIn < LENF_W'(2))           loadLen = BL_W'(2);
    else if (lenIn > LENF_W'(DATA_W)) loadLen = BL_W'(DATA_W);
    else                              loadLen = BL_W'(lenIn);
  end

  assign cntZero = (cnt == '0);

  always_comb begin
    stb          = '0;
    stb.load     = (state == ST_IDLE) && start;
    stb.sample   = ((state == ST_LEAD) || (state == ST_INACT)) && cntZero;
    stb.shiftOut = (state == ST_ACT) && cntZero && (bitsLeft != BL_W'(1));
    stb.finish   = (state == ST_TRAIL) && cntZero;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      bitsLeft <= '0;
      psReg    <= '0;
      polReg   <= 1'b0;
      trailReg <= '0;
      sclk     <= 1'b0;
      csN      <= 1'b1;
      busy     <= 1'b0;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          sclk <= polIn;
          if (start) begin
            psReg    <= psIn;
            polReg   <= polIn;
            trailReg <= trailIn;
            bitsLeft <= loadLen;
            cnt      <= leadLen - CNT_W'(1);
            csN      <= 1'b0;
            busy     <= 1'b1;
            state    <= ST_LEAD;
          end
        end
        ST_LEAD, ST_INACT: begin
          if (cntZero) begin
            sclk  <= ~polReg;
            cnt   <= CNT_W'(actHalf) - CNT_W'(1);
            state <= ST_ACT;
          end else begin
            cnt <= cnt - CNT_W'(1);
          end
        end
        ST_ACT: begin
          if (cntZero) begin
            sclk <= polReg;
            if (bitsLeft == BL_W'(1)) begin
              cnt   <= CNT_W'(trailReg);
              state <= ST_TRAIL;
            end else begin
              bitsLeft <= bitsLeft - BL_W'(1);
              cnt      <= CNT_W'(idleHalf) - CNT_W'(1);
              state    <= ST_INACT;
            end
          end else begin
            cnt <= cnt - CNT_W'(1);
          end
        end
        ST_TRAIL: begin
          if (cntZero) begin
            csN   <= 1'b1;
            busy  <= 1'b0;
            done  <= 1'b1;
            state <= ST_IDLE;
          end else begin
            cnt <= cnt - CNT_W'(1);
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spi_dly_dpath.sv
module spi_dly_dpath
  import spi_dly_pkg::*;
#(
  parameter int DATA_W = 16,
  localparam int BL_W  = $clog2(DATA_W) + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         stb,
  input  logic [DATA_W-1:0] txWord,
  input  logic [BL_W-1:0]   loadLen,
  input  logic              miso,
  output logic              mosi,
  output logic [DATA_W-1:0] rxWord
);
  logic [DATA_W-1:0] txShift;
  logic [DATA_W-1:0] rxShift;

  assign mosi = txShift[DATA_W-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txShift <= '0;
      rxShift <= '0;
      rxWord  <= '0;
    end else begin
      if (stb.load) begin
        txShift <= txWord << (DATA_W - int'(loadLen));
        rxShift <= '0;
      end else begin
        if (stb.shiftOut) txShift <= {txShift[DATA_W-2:0], 1'b0};
        if (stb.sample)   rxShift <= {rxShift[DATA_W-2:0], miso};
      end
      if (stb.finish) rxWord <= rxShift;
    end
  end
endmodule

// File: rtl/spi_dly_master.sv
module spi_dly_master
  import spi_dly_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [FMT_W-1:0]  fmtWord,
  input  logic [DLYW_W-1:0] dlyWord,
  input  logic              start,
  input  logic [DATA_W-1:0] txWord,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rxWord,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso,
  output logic              csN
);
  localparam int BL_W = $clog2(DATA_W) + 1;

  dpStrobe_t       stb;
  logic [BL_W-1:0] loadLen;

  spi_dly_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .start   (start),
    .lenIn   (fmtWord[FMT_LEN_LSB +: LENF_W]),
    .psIn    (fmtWord[FMT_PS_LSB +: PS_W]),
    .holdIn  (fmtWord[FMT_HOLD_BIT]),
    .polIn   (fmtWord[FMT_POL_BIT]),
    .leadIn  (dlyWord[DLY_LED_LSB +: DLY_W]),
    .trailIn (dlyWord[DLY_TRL_LSB +: DLY_W]),
    .loadLen (loadLen),
    .stb     (stb),
    .sclk    (sclk),
    .csN     (csN),
    .busy    (busy),
    .done    (done)
  );

  spi_dly_dpath #(.DATA_W(DATA_W)) u_dpath (
    .clk     (clk),
    .rstN    (rstN),
    .stb     (stb),
    .txWord  (txWord),
    .loadLen (loadLen),
    .miso    (miso),
    .mosi    (mosi),
    .rxWord  (rxWord)
  );
endmodule

// File: rtl/spi_dly_master_chk.sv
module spi_dly_master_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic              csN,
  input logic [DATA_W-1:0] rxWord
);
  AST_BUSY_HOLDS_CS: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !csN); // R7
  AST_IDLE_RELEASES_CS: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> csN); // R7
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R7
  AST_DONE_AT_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (csN && $past(!csN))); // R7
  AST_START_DROPS_CS: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy) |=> !csN); // R3
  AST_RX_ONLY_AT_DONE: assert property (@(posedge clk) disable iff (!rstN)
    !done |-> $stable(rxWord)); // R6
endmodule

bind spi_dly_master spi_dly_master_chk #(.DATA_W(DATA_W)) u_chk (
  .clk    (clk),
  .rstN   (rstN),
  .start  (start),
  .busy   (busy),
  .done   (done),
  .csN    (csN),
  .rxWord (rxWord)
);

// File: tb/tb_spi_dly_master.sv
module tb_spi_dly_master;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [17:0] fmtWord = '0;
  logic [15:0] dlyWord = '0;
  logic        start = 1'b0;
  logic [15:0] txWord = '0;
  logic        miso = 1'b0;
  logic        busy, done, sclk, mosi, csN;
  logic [15:0] rxWord;

  int nChk = 0;
  int nFail = 0;

  always #4 clk = ~clk;

  spi_dly_master dut (
    .clk(clk), .rstN(rstN), .fmtWord(fmtWord), .dlyWord(dlyWord),
    .start(start), .txWord(txWord), .busy(busy), .done(done),
    .rxWord(rxWord), .sclk(sclk), .mosi(mosi), .miso(miso), .csN(csN)
  );

  // {fmt, dly, tx, slave word}
  localparam logic [65:0] VEC [7] = '{
    {18'h0_0008, 16'h0000, 16'h00A5, 16'h003C},
    {18'h3_0110, 16'h0302, 16'hBEEF, 16'h1234},
    {18'h1_0405, 16'h0A05, 16'h0013, 16'h000D},
    {18'h2_020C, 16'h0100, 16'hFABC, 16'hFF0F},
    {18'h0_0000, 16'h0001, 16'hFFFE, 16'h0001},
    {18'h3_FF01, 16'hFFFF, 16'h0002, 16'h0003},
    {18'h0_03FF, 16'h0403, 16'h8001, 16'hA55A}
  };

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
  endtask

  task automatic runXfer(input logic [17:0] fmt, input logic [15:0] dly,
                         input logic [15:0] tx, input logic [15:0] slv,
                         input bit disturb);
    int ps, per, h1, h2, len, lead, trail, cyc, lastChg, edges, act, slvIdx;
    int gapBad, gapAct, gapExp, mosiBad, doneEarly;
    logic pol, prevSclk;
    logic [15:0] mask;
    ps   = int'(fmt[15:8]);
    per  = (ps == 0) ? 2 : ps + 1;
    h1   = per / 2;
    h2   = per - h1;
    len  = int'(fmt[7:0]);
    if (len < 2) len = 2;
    if (len > 16) len = 16;
    pol  = fmt[17];
    lead = h1 + int'(dly[15:8]) + 2 + int'(fmt[16]);
    mask = 16'((32'h1 << len) - 1);
    @(negedge clk);
    fmtWord = fmt; dlyWord = dly; txWord = tx;
    slvIdx = len - 1;
    miso = slv[slvIdx];
    @(negedge clk);
    chk(sclk == pol, "R2", "idle sclk level", int'(sclk), int'(pol));
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(csN == 1'b0, "R3", "csN low after accept", int'(csN), 0);
    chk(mosi == tx[len-1], "R5", "first bit at cs fall", int'(mosi), int'(tx[len-1]));
    cyc = 0; lastChg = 0; edges = 0; act = 0; prevSclk = sclk;
    gapBad = 0; gapAct = 0; gapExp = 0; mosiBad = 0; doneEarly = 0; trail = -1;
    while (cyc < 20000) begin
      @(negedge clk);
      cyc++;
      if (disturb && cyc == 2) begin
        start = 1'b1;
        fmtWord = fmt ^ 18'h3_FF0F;
        dlyWord = ~dly;
        txWord = ~tx;
      end
      if (disturb && cyc == 3) start = 1'b0;
      if (csN) begin
        trail = cyc - lastChg;
        break;
      end
      if (done) doneEarly++;
      if (sclk != prevSclk) begin
        edges++;
        if (edges == 1) begin
          chk((cyc - lastChg) == lead, "R3", "lead cycles", cyc - lastChg, lead);
        end else if ((cyc - lastChg) != ((edges % 2 == 0) ? h2 : h1)) begin
          if (gapBad == 0) begin
            gapAct = cyc - lastChg;
            gapExp = (edges % 2 == 0) ? h2 : h1;
          end
          gapBad++;
        end
        if (sclk != pol) begin
          if (act < len && mosi != tx[len-1-act]) mosiBad++;
          act++;
        end else begin
          slvIdx--;
          if (slvIdx >= 0) miso = slv[slvIdx];
        end
        lastChg = cyc;
        prevSclk = sclk;
      end
    end
    chk(gapBad == 0, "R1", "half-period spacing", gapAct, gapExp);
    chk(edges == 2 * len, "R5", "serial edge count", edges, 2 * len);
    chk(mosiBad == 0, "R5", "mosi bits wrong", mosiBad, 0);
    chk(trail == int'(dly[7:0]) + 1, "R4", "trail cycles", trail, int'(dly[7:0]) + 1);
    chk(doneEarly == 0 && done, "R7", "done at release", int'(done), 1);
    chk(busy == 1'b0, "R7", "busy low at done", int'(busy), 0);
    chk(rxWord == (slv & mask), "R6", "received word", int'(rxWord), int'(slv & mask));
    @(negedge clk);
    chk(done == 1'b0, "R7", "done width", int'(done), 0);
    fmtWord = fmt; dlyWord = dly; txWord = tx;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nChk++; nFail++;
    $display("FAIL watchdog: actual timeout expected finish");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(csN == 1'b1, "R10", "reset csN", int'(csN), 1);
    chk(sclk == 1'b0, "R10", "reset sclk", int'(sclk), 0);
    chk(busy == 1'b0 && done == 1'b0, "R10", "reset busy/done", int'(busy) + int'(done), 0);
    chk(rxWord == 16'h0, "R10", "reset rxWord", int'(rxWord), 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    for (int i = 0; i < 7; i++) begin
      runXfer(VEC[i][65:48], VEC[i][47:32], VEC[i][31:16], VEC[i][15:0], 1'b0);
    end

    // R8 and R9: start and configuration changes during a transfer
    runXfer(18'h1_0405, 16'h0A05, 16'h0013, 16'h000D, 1'b1);
    begin
      int extra;
      extra = 0;
      for (int k = 0; k < 8; k++) begin
        @(negedge clk);
        if (!csN || done) extra++;
      end
      chk(extra == 0, "R8", "no transfer after ignored start", extra, 0);
    end

    // back-to-back transfer right after the disturbed one (R9 restored config)
    runXfer(18'h2_0006, 16'h0201, 16'h0029, 16'h0016, 1'b0);

    summary();
    $finish;
  end
endmodule